// File: doc/BRIEF.md
# Synthesizer Latch Programming Controller

This block is the control-register front end of a frequency synthesizer. It takes fully assembled programming words as a parallel bus with a one-cycle load strobe. It sends each word to one of four destinations, chosen by the word's two lowest bits: a reference-divider latch, a dual-modulus (A/B) divider latch, a function latch, or an initialization latch. The initialization latch writes the same fields as the function latch.

From the latched state, the block drives the controls for the divider chain and the charge pump. It produces single-cycle counter reset pulses and a counter hold. It drives the charge-pump high-impedance control, and a power-down output that combines an immediate chip-enable shutdown with a synchronous shutdown triggered by the reset pulse. It also enables the fast-lock timer.

An initialization load fires a reset pulse. It also arms a one-shot, so the next A/B load fires the same pulse once. Software brings the synthesizer up by writing the initialization word, then the reference word, then the A/B word. The dividers then start in close phase alignment.

Top module: `synth_latch_ctl`

## Requirements
- R1: On a load strobe, word bits [1:0] pick the destination: 00 reference latch (divider in bits [15:2]), 01 A/B latch (A in bits [7:2], B in bits [20:8]), 10 function latch, 11 initialization latch. Latches that are not addressed keep their contents.
- R2: An initialization load (11) writes the function fields. In the cycle right after the strobe, it raises cnt_reset and cp_hiz for exactly one cycle. A function load (10) produces no pulse.
- R3: The first A/B load after an initialization load produces the same one-cycle pulse in the cycle after its strobe. Later A/B loads produce no pulse until another initialization load. Reference loads never produce one.
- R4: While function bit 2 (counter hold) is 1, cnt_reset and cp_hiz stay high and power_down is not asserted because of it. Writing the bit to 0 releases both on the next cycle.
- R5: A reset pulse that occurs while ce=1, function bit 3 (PD1)=1 and function bit 6 (PD2)=0 raises power_down from the following cycle. It stays high until a function or initialization load writes PD1=0 or PD2=1.
- R6: ce=0 forces power_down high at once, without waiting for a clock edge. Loads made while ce=0 still update their latches, and latched contents survive ce cycling.
- R7: Function bit 5 forces cp_hiz high when 1 and lets it go low when 0.
- R8: fl_timer_en equals function bit 10.
- R9: Function fields are exported: bit 4 phase polarity, bits [8:7] prescaler select, bits [13:11] current setting 1, bits [16:14] current setting 2.
- R10: After reset all latches are zero, the one-shot is disarmed (an A/B load makes no pulse), cnt_reset is 0, and cp_hiz is 1 until the first function or initialization load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| ce | input | 1 | Chip enable; low means immediate power-down |
| load | input | 1 | One-cycle strobe for word |
| word | input | WORD_W (24) | Programming word |
| ref_div | output | REF_W (14) | Reference divider value |
| a_div | output | A_W (6) | A divider value |
| b_div | output | B_W (13) | B divider value |
| cnt_reset | output | 1 | Counter reset (pulse or hold) |
| cp_hiz | output | 1 | Charge pump high-impedance |
| power_down | output | 1 | Device power-down |
| fl_timer_en | output | 1 | Fast-lock timer enable |
| cur_set1 | output | 3 | Charge-pump current setting 1 |
| cur_set2 | output | 3 | Charge-pump current setting 2 |
| presc_sel | output | 2 | Prescaler select |
| pd_polarity | output | 1 | Phase detector polarity |

## Verification
The bench first makes an A/B load straight after reset, before any initialization word. This exposes an arm flag that comes out of reset set. It then makes two A/B loads after an initialization word, which catches a one-shot that never disarms or never fires. The synchronous power-down scenario compares a PD1/PD2 combination that should shut down with one that should not, and confirms that the shutdown clears when PD1 is rewritten. A design that decoded the bit pair wrongly would stay powered down. Chip enable is dropped and sampled before any clock edge, so a registered shutdown path shows up as a late power-down. A reference load made while chip enable is low catches a design that blocks writes in power-down.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
    localparam int FB_HOLD   = 2;
    localparam int FB_PD1    = 3;
    localparam int FB_POL    = 4;
    localparam int FB_CPTRI  = 5;
    localparam int FB_PD2    = 6;
    localparam int FB_PRE_LO = 7;
    localparam int FB_FL     = 10;
    localparam int FB_C1_LO  = 11;
    localparam int FB_C2_LO  = 14;
    localparam int FN_TOP    = 16;

    typedef enum logic [1:0] {
        DST_REF  = 2'b00,
        DST_AB   = 2'b01,
        DST_FN   = 2'b10,
        DST_INIT = 2'b11
    } dst_e;

    typedef struct packed {
        logic       hold;
        logic       pd1;
        logic       pol;
        logic       cptri;
        logic       pd2;
        logic [1:0] presc;
        logic       fl;
        logic [2:0] cur1;
        logic [2:0] cur2;
    } fn_t;
endpackage

// File: rtl/synth_ctl_decode.sv
module synth_ctl_decode
    import synth_ctl_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              we_ref,
    output logic              we_ab,
    output logic              we_fn,
    output logic              init_ld,
    output fn_t               fn_new
);
    dst_e dst;
    logic unused_bits;

    assign dst         = dst_e'(word[1:0]);
    assign unused_bits = ^{word[9], word[WORD_W-1:FN_TOP+1]};

    always_comb begin
        we_ref  = load && (dst == DST_REF);
        we_ab   = load && (dst == DST_AB);
        init_ld = load && (dst == DST_INIT);
        we_fn   = load && ((dst == DST_FN) || (dst == DST_INIT));
    end

    always_comb begin
        fn_new.hold  = word[FB_HOLD];
        fn_new.pd1   = word[FB_PD1];
        fn_new.pol   = word[FB_POL];
        fn_new.cptri = word[FB_CPTRI];
        fn_new.pd2   = word[FB_PD2];
        fn_new.presc = word[FB_PRE_LO +: 2];
        fn_new.fl    = word[FB_FL];
        fn_new.cur1  = word[FB_C1_LO +: 3];
        fn_new.cur2  = word[FB_C2_LO +: 3];
    end
endmodule

// File: rtl/synth_ctl_rstgen.sv
module synth_ctl_rstgen (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic init_ld,
    input  logic we_ab,
    input  logic we_fn,
    input  logic new_pd1,
    input  logic new_pd2,
    input  logic cur_pd1,
    input  logic cur_pd2,
    output logic pulse,
    output logic sync_pd
);
    typedef struct packed {
        logic pulse;
        logic armed;
        logic spd;
    } rg_t;

    rg_t rg_d, rg_q;

    always_comb begin
        rg_d       = rg_q;
        rg_d.pulse = init_ld || (we_ab && rg_q.armed);
        if (init_ld)
            rg_d.armed = 1'b1;
        else if (we_ab)
            rg_d.armed = 1'b0;
        if (rg_q.pulse && ce && cur_pd1 && !cur_pd2)
            rg_d.spd = 1'b1;
        if (we_fn && (!new_pd1 || new_pd2))
            rg_d.spd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rg_q <= '0;
        else
            rg_q <= rg_d;
    end

    assign pulse   = rg_q.pulse;
    assign sync_pd = rg_q.spd;
endmodule

// File: rtl/synth_latch_ctl.sv
module synth_latch_ctl
    import synth_ctl_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int REF_W  = 14,
    parameter int A_W    = 6,
    parameter int B_W    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic [REF_W-1:0]  ref_div,
    output logic [A_W-1:0]    a_div,
    output logic [B_W-1:0]    b_div,
    output logic              cnt_reset,
    output logic              cp_hiz,
    output logic              power_down,
    output logic              fl_timer_en,
    output logic [2:0]        cur_set1,
    output logic [2:0]        cur_set2,
    output logic [1:0]        presc_sel,
    output logic              pd_polarity
);
    localparam int REF_LO = 2;
    localparam int A_LO   = 2;
    localparam int B_LO   = A_LO + A_W;

    typedef struct packed {
        logic [REF_W-1:0] refv;
        logic [A_W-1:0]   a;
        logic [B_W-1:0]   b;
        fn_t              fn;
        logic             seen;
    } lat_t;

    lat_t st_d, st_q;
    logic we_ref, we_ab, we_fn, init_ld;
    fn_t  fn_new;
    logic pulse_w, spd_w;

    synth_ctl_decode #(.WORD_W(WORD_W)) u_dec (
        .load    (load),
        .word    (word),
        .we_ref  (we_ref),
        .we_ab   (we_ab),
        .we_fn   (we_fn),
        .init_ld (init_ld),
        .fn_new  (fn_new)
    );

    synth_ctl_rstgen u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .init_ld (init_ld),
        .we_ab   (we_ab),
        .we_fn   (we_fn),
        .new_pd1 (fn_new.pd1),
        .new_pd2 (fn_new.pd2),
        .cur_pd1 (st_q.fn.pd1),
        .cur_pd2 (st_q.fn.pd2),
        .pulse   (pulse_w),
        .sync_pd (spd_w)
    );

    always_comb begin
        st_d = st_q;
        if (we_ref)
            st_d.refv = word[REF_LO +: REF_W];
        if (we_ab) begin
            st_d.a = word[A_LO +: A_W];
            st_d.b = word[B_LO +: B_W];
        end
        if (we_fn) begin
            st_d.fn   = fn_new;
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign ref_div     = st_q.refv;
    assign a_div       = st_q.a;
    assign b_div       = st_q.b;
    assign cnt_reset   = pulse_w || st_q.fn.hold;
    assign cp_hiz      = pulse_w || st_q.fn.hold || st_q.fn.cptri || !st_q.seen;
    assign power_down  = !ce || spd_w;
    assign fl_timer_en = st_q.fn.fl;
    assign cur_set1    = st_q.fn.cur1;
    assign cur_set2    = st_q.fn.cur2;
    assign presc_sel   = st_q.fn.presc;
    assign pd_polarity = st_q.fn.pol;
endmodule

// File: rtl/synth_latch_ctl_chk.sv
module synth_latch_ctl_chk #(
    parameter int WORD_W = 24,
    parameter int REF_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce,
    input logic              load,
    input logic [WORD_W-1:0] word,
    input logic              rst_pulse,
    input logic              cnt_reset,
    input logic              cp_hiz,
    input logic              power_down,
    input logic              fl_timer_en,
    input logic [REF_W-1:0]  ref_div
);
    AST_INIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word[1:0] == 2'b11) |=> cnt_reset); // R2
    AST_FN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word[1:0] == 2'b10) |=> !rst_pulse); // R2
    AST_PULSE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> (cp_hiz && cnt_reset)); // R2
    AST_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> $past(load && word[0])); // R3
    AST_REF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word[1:0] == 2'b00) |=> !rst_pulse); // R3
    AST_REF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && word[1:0] == 2'b00) |=> $stable(ref_div)); // R1
    AST_ASYNC_PD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |-> power_down); // R6
    AST_FL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && word[1]) |=> $stable(fl_timer_en)); // R8
endmodule

bind synth_latch_ctl synth_latch_ctl_chk #(.WORD_W(WORD_W), .REF_W(REF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce          (ce),
    .load        (load),
    .word        (word),
    .rst_pulse   (pulse_w),
    .cnt_reset   (cnt_reset),
    .cp_hiz      (cp_hiz),
    .power_down  (power_down),
    .fl_timer_en (fl_timer_en),
    .ref_div     (ref_div)
);

// File: tb/sim_synth_latch_ctl.sv
module sim_synth_latch_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b1;
    logic        load = 1'b0;
    logic [23:0] word = '0;
    logic [13:0] ref_div;
    logic [5:0]  a_div;
    logic [12:0] b_div;
    logic        cnt_reset, cp_hiz, power_down, fl_timer_en, pd_polarity;
    logic [2:0]  cur_set1, cur_set2;
    logic [1:0]  presc_sel;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    synth_latch_ctl u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .load(load), .word(word),
        .ref_div(ref_div), .a_div(a_div), .b_div(b_div),
        .cnt_reset(cnt_reset), .cp_hiz(cp_hiz), .power_down(power_down),
        .fl_timer_en(fl_timer_en), .cur_set1(cur_set1), .cur_set2(cur_set2),
        .presc_sel(presc_sel), .pd_polarity(pd_polarity)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] fword(input logic hold, input logic pd1, input logic pol,
            input logic cptri, input logic pd2, input logic [1:0] presc, input logic fl,
            input logic [2:0] c1, input logic [2:0] c2, input logic [1:0] dst);
        logic [23:0] w;
        w = '0;
        w[1:0] = dst; w[2] = hold; w[3] = pd1; w[4] = pol; w[5] = cptri; w[6] = pd2;
        w[8:7] = presc; w[10] = fl; w[13:11] = c1; w[16:14] = c2;
        return w;
    endfunction

    task automatic do_load(input logic [23:0] w);
        @(negedge clk);
        word = w; load = 1'b1;
        @(negedge clk);
        load = 1'b0; word = '0;
    endtask

    task automatic t_reset;
        chk("R10 ref", ref_div, 0);
        chk("R10 cnt_reset", cnt_reset, 0);
        chk("R10 cp_hiz", cp_hiz, 1);
        chk("R10 fl", fl_timer_en, 0);
        chk("R10 pd", power_down, 0);
    endtask

    task automatic t_route;
        do_load({8'h0, 14'h1A5C, 2'b00});
        chk("R1 ref", ref_div, 14'h1A5C);
        chk("R3 ref no pulse", cnt_reset, 0);
        do_load({3'b0, 13'h0B3D, 6'h2A, 2'b01});
        chk("R1 a", a_div, 6'h2A);
        chk("R1 b", b_div, 13'h0B3D);
        chk("R1 ref kept", ref_div, 14'h1A5C);
        chk("R10 unarmed ab", cnt_reset, 0);
        do_load(fword(0, 0, 1, 0, 0, 2'b10, 0, 3'd5, 3'd3, 2'b10));
        chk("R2 fn no pulse", cnt_reset, 0);
        chk("R7 cp enabled", cp_hiz, 0);
        chk("R9 pol", pd_polarity, 1);
        chk("R9 presc", presc_sel, 2'b10);
        chk("R9 cur1", cur_set1, 3'd5);
        chk("R9 cur2", cur_set2, 3'd3);
        chk("R1 a kept", a_div, 6'h2A);
    endtask

    task automatic t_init;
        do_load(fword(0, 0, 0, 0, 0, 2'b01, 0, 3'd2, 3'd6, 2'b11));
        chk("R2 init pulse", cnt_reset, 1);
        chk("R2 init hiz", cp_hiz, 1);
        chk("R2 init fields", {presc_sel, cur_set1, cur_set2}, {2'b01, 3'd2, 3'd6});
        @(negedge clk);
        chk("R2 pulse ends", cnt_reset, 0);
        chk("R2 hiz ends", cp_hiz, 0);
        do_load({3'b0, 13'h0011, 6'h05, 2'b01});
        chk("R3 first ab pulse", cnt_reset, 1);
        @(negedge clk);
        chk("R3 first ab pulse ends", cnt_reset, 0);
        do_load({3'b0, 13'h0022, 6'h06, 2'b01});
        chk("R3 second ab no pulse", cnt_reset, 0);
        chk("R1 ab second", a_div, 6'h06);
    endtask

    task automatic t_hold;
        do_load(fword(1, 0, 0, 0, 0, 2'b00, 0, 3'd1, 3'd1, 2'b10));
        for (int i = 0; i < 4; i++) begin
            chk("R4 hold rst", cnt_reset, 1);
            chk("R4 hold hiz", cp_hiz, 1);
            chk("R4 hold no pd", power_down, 0);
            @(negedge clk);
        end
        do_load(fword(0, 0, 0, 0, 0, 2'b00, 0, 3'd1, 3'd1, 2'b10));
        chk("R4 release rst", cnt_reset, 0);
        chk("R4 release hiz", cp_hiz, 0);
    endtask

    task automatic t_cptri;
        do_load(fword(0, 0, 0, 1, 0, 2'b00, 0, 3'd0, 3'd0, 2'b10));
        chk("R7 forced hiz", cp_hiz, 1);
        chk("R7 no reset", cnt_reset, 0);
        do_load(fword(0, 0, 0, 0, 0, 2'b00, 0, 3'd0, 3'd0, 2'b10));
        chk("R7 hiz off", cp_hiz, 0);
    endtask

    task automatic t_fl;
        do_load(fword(0, 0, 0, 0, 0, 2'b00, 1, 3'd0, 3'd0, 2'b10));
        chk("R8 fl on", fl_timer_en, 1);
        do_load({8'h0, 14'h0003, 2'b00});
        chk("R8 fl kept", fl_timer_en, 1);
        do_load(fword(0, 0, 0, 0, 0, 2'b00, 0, 3'd0, 3'd0, 2'b10));
        chk("R8 fl off", fl_timer_en, 0);
    endtask

    task automatic t_syncpd;
        do_load(fword(0, 1, 0, 0, 0, 2'b00, 0, 3'd4, 3'd4, 2'b11));
        chk("R5 pulse", cnt_reset, 1);
        chk("R5 not yet", power_down, 0);
        @(negedge clk);
        chk("R5 sync pd", power_down, 1);
        @(negedge clk);
        chk("R5 sync pd held", power_down, 1);
        do_load(fword(0, 0, 0, 0, 0, 2'b00, 0, 3'd4, 3'd4, 2'b10));
        chk("R5 pd cleared", power_down, 0);
        do_load(fword(0, 1, 0, 0, 1, 2'b00, 0, 3'd4, 3'd4, 2'b11));
        @(negedge clk);
        chk("R5 pd2 blocks", power_down, 0);
    endtask

    task automatic t_async;
        @(negedge clk);
        ce = 1'b0;
        #2;
        chk("R6 immediate pd", power_down, 1);
        do_load({8'h0, 14'h2AB5, 2'b00});
        chk("R6 load while off", ref_div, 14'h2AB5);
        chk("R6 still pd", power_down, 1);
        #3;
        ce = 1'b1;
        #2;
        chk("R6 pd released", power_down, 0);
        chk("R6 fields kept", cur_set1, 3'd4);
        chk("R6 ref kept", ref_div, 14'h2AB5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_route();
        t_init();
        t_hold();
        t_cptri();
        t_fl();
        t_syncpd();
        t_async();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule